// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Interface

This block is the bit-level front end of a slave on an open-drain single-wire bus with a pullup. It runs from a free-running system clock. A divider turns that clock into a microsecond tick, and the divider restarts on every falling edge that the master causes, so each timing decision counts from the master's edge and not from an arbitrary tick phase. The line input passes through a two-stage synchroniser. The only thing the block drives is a registered pull-down enable for an external open-drain transistor.

A low period of 480 µs or longer counts as a bus reset. When the line rises again, the block reports the reset upward, waits, and pulls the line low itself as the presence answer. Any shorter low period is a time slot, and the block samples it 30 µs after the falling edge. If the layer above has armed a zero to transmit, the block holds the line low across that sample point, which makes the slot a read-zero. The sampled bit is handed upward with a one-cycle strobe after the line has returned high. Falling edges that the block causes while it drives the line are never mistaken for master slots.

Top module: `sw_slave_bitif`

## Requirements
- R1: After the synchronous reset `rst`, `pull_en`, `rx_strobe`, `bus_reset` and `tx_taken` are all 0.
- R2: A low period of at least `RST_US` (480) µs is a bus reset. When the line rises again, `bus_reset` pulses once. No `rx_strobe` is issued for that low period.
- R3: After the rise that ends a bus reset, `pull_en` goes to 1 `PD_WAIT_US` (30) µs later, within ±1 µs. It stays at 1 for `PD_LOW_US` (120) µs, within ±1 µs.
- R4: In a slot where the line is high again before the 30 µs sample point, exactly one `rx_strobe` is issued, with `rx_bit` = 1.
- R5: In a slot where the line is still low at the sample point, `rx_bit` = 0. A low period of up to 479 µs gives bit 0 and no `bus_reset`.
- R6: `rx_strobe` is issued no earlier than `SAMPLE_US` (30) µs after the falling edge. It is issued only after the line has returned high.
- R7: If `tx_en` = 1 and `tx_bit` = 0 when a slot starts, `tx_taken` pulses and `pull_en` rises within 1 µs of the falling edge. The line is therefore low 15 µs into the slot. `pull_en` is released `HOLD_US` (35) µs after the falling edge, within ±1 µs.
- R8: If `tx_en` = 1 and `tx_bit` = 1, `tx_taken` pulses and `pull_en` stays 0. If `tx_en` = 0, neither `tx_taken` nor `pull_en` is asserted.
- R9: Falling edges caused by the block's own `pull_en` (presence or read-zero) start no slot. One master slot gives exactly one `rx_strobe`, and the presence answer gives none.
- R10: The microsecond tick is `CLK_HZ`/1,000,000 clock cycles long. All the durations above scale with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sensed bus level (asynchronous) |
| pull_en | output | 1 | Enables the external open-drain pull-down |
| rx_strobe | output | 1 | One-cycle strobe: a slot's bit is ready |
| rx_bit | output | 1 | Bit sampled in the last completed slot |
| tx_en | input | 1 | A bit is armed for the next slot |
| tx_bit | input | 1 | Value of the armed bit |
| tx_taken | output | 1 | One-cycle strobe: the armed bit was consumed by a slot |
| bus_reset | output | 1 | One-cycle strobe: a bus reset ended |

## Verification
The hardest case to reach is a slot that the block drives itself. During a read-zero the line stays low after the master has let go, and during presence the falling edge is the block's own. In both cases the synchroniser delays the echo of `pull_en` by several cycles. The bench models the wired-AND bus as the NOR of the master's pull and `pull_en`, so the block sees its own edges arrive with that same delay. The bench then counts strobes and pull-down edges, and shows that presence produces no strobe and that a read-zero produces exactly one.

// File: rtl/sw_bit_pkg.sv
package sw_bit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RSTLOW,
    ST_PDWAIT,
    ST_PDDRV,
    ST_PDREL
  } sw_state_e;

  function automatic int cycles_per_us(input int clk_hz);
    return clk_hz / 1_000_000;
  endfunction

endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || restart)                div_q <= '0;
    else if (div_q == W'(DIV - 1))     div_q <= '0;
    else                               div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == W'(DIV - 1)) && !restart;

  // R10: a restart realigns the divider, so no tick can follow at once
  assert_restart_aligns_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);

endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign line_s = s2_q;
  assign fall   = prev_q && !s2_q;

endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine
  import sw_bit_pkg::*;
#(
  parameter int US_W       = 10,
  parameter int RST_US     = 480,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_s,
  input  logic fall,
  input  logic tx_en,
  input  logic tx_bit,
  output logic restart,
  output logic pull_en,
  output logic rx_strobe,
  output logic rx_bit,
  output logic tx_taken,
  output logic bus_reset
);
  sw_state_e      state_q;
  logic [US_W-1:0] cnt_q;
  logic           smp_q, smpd_q;

  assign restart = ((state_q == ST_IDLE) && fall) ||
                   ((state_q == ST_RSTLOW) && line_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      smp_q     <= 1'b1;
      smpd_q    <= 1'b0;
      pull_en   <= 1'b0;
      rx_strobe <= 1'b0;
      rx_bit    <= 1'b1;
      tx_taken  <= 1'b0;
      bus_reset <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      tx_taken  <= 1'b0;
      bus_reset <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_SLOT;
            cnt_q   <= '0;
            smpd_q  <= 1'b0;
            if (tx_en) begin
              tx_taken <= 1'b1;
              pull_en  <= !tx_bit;
            end
          end
        end
        ST_SLOT: begin
          if (smpd_q && line_s && !pull_en) begin
            rx_strobe <= 1'b1;
            rx_bit    <= smp_q;
            state_q   <= ST_IDLE;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == US_W'(SAMPLE_US - 1)) begin
              smp_q  <= line_s;
              smpd_q <= 1'b1;
            end
            if (cnt_q == US_W'(HOLD_US - 1))
              pull_en <= 1'b0;
            if ((cnt_q == US_W'(RST_US - 1)) && !line_s)
              state_q <= ST_RSTLOW;
          end
        end
        ST_RSTLOW: begin
          if (line_s) begin
            state_q   <= ST_PDWAIT;
            cnt_q     <= '0;
            bus_reset <= 1'b1;
          end
        end
        ST_PDWAIT: begin
          if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == US_W'(PD_WAIT_US - 1)) begin
              state_q <= ST_PDDRV;
              cnt_q   <= '0;
              pull_en <= 1'b1;
            end
          end
        end
        ST_PDDRV: begin
          if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == US_W'(PD_LOW_US - 1)) begin
              state_q <= ST_PDREL;
              pull_en <= 1'b0;
            end
          end
        end
        ST_PDREL: begin
          if (line_s) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a slot delivers its bit as a single-cycle strobe
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe);

  // R9: a bit is never delivered while the block still pulls the line
  assert_strobe_released_R9: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> !pull_en);

  // R7: consuming an armed bit drives the line exactly for a zero
  assert_read_drive_R7: assert property (@(posedge clk) disable iff (rst)
    tx_taken |-> (pull_en == !$past(tx_bit)));

  // R2: the end of a reset carries neither a bit nor a pull-down
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> (!rx_strobe && !pull_en));

endmodule

// File: rtl/sw_slave_bitif.sv
module sw_slave_bitif
  import sw_bit_pkg::*;
#(
  parameter int CLK_HZ     = 8_000_000,
  parameter int RST_US     = 480,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic pull_en,
  output logic rx_strobe,
  output logic rx_bit,
  input  logic tx_en,
  input  logic tx_bit,
  output logic tx_taken,
  output logic bus_reset
);
  localparam int DIV  = cycles_per_us(CLK_HZ);
  localparam int US_W = $clog2(RST_US + PD_LOW_US + 1);

  logic tick, restart, line_s, fall;

  sw_line_sync i_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (line_in),
    .line_s  (line_s),
    .fall    (fall)
  );

  sw_tick_gen #(.DIV(DIV)) i_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  sw_slot_engine #(
    .US_W       (US_W),
    .RST_US     (RST_US),
    .PD_WAIT_US (PD_WAIT_US),
    .PD_LOW_US  (PD_LOW_US),
    .SAMPLE_US  (SAMPLE_US),
    .HOLD_US    (HOLD_US)
  ) i_engine (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .line_s    (line_s),
    .fall      (fall),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .restart   (restart),
    .pull_en   (pull_en),
    .rx_strobe (rx_strobe),
    .rx_bit    (rx_bit),
    .tx_taken  (tx_taken),
    .bus_reset (bus_reset)
  );

endmodule

// File: tb/test_sw_slave_bitif.sv
module test_sw_slave_bitif;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8_000_000;
  localparam int US         = CLK_HZ / 1_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_low = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b1;
  logic line_in;
  logic pull_en, rx_strobe, rx_bit, tx_taken, bus_reset;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_rx = 0, n_br = 0, n_tk = 0, n_pr = 0;
  int last_rx_cyc = 0, pr_cyc = 0, pf_cyc = 0;
  logic last_rx_bit = 1'b1;
  logic pull_d = 1'b0;

  assign line_in = !(m_low || pull_en);

  sw_slave_bitif #(.CLK_HZ(CLK_HZ)) i_sw_slave_bitif (
    .clk(clk), .rst(rst), .line_in(line_in), .pull_en(pull_en),
    .rx_strobe(rx_strobe), .rx_bit(rx_bit), .tx_en(tx_en), .tx_bit(tx_bit),
    .tx_taken(tx_taken), .bus_reset(bus_reset)
  );

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_strobe) begin n_rx++; last_rx_bit = rx_bit; last_rx_cyc = cyc; end
    if (bus_reset) n_br++;
    if (tx_taken) n_tk++;
    if (pull_en && !pull_d) begin n_pr++; pr_cyc = cyc; end
    if (!pull_en && pull_d) pf_cyc = cyc;
    pull_d = pull_en;
  end

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * US) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(!pull_en, "R1 pull_en", pull_en, 0);
    chk(!rx_strobe && !bus_reset && !tx_taken, "R1 strobes", rx_strobe + bus_reset + tx_taken, 0);
  endtask

  task automatic t_bus_reset();
    int rx0 = n_rx, br0 = n_br, pr0 = n_pr, t_rel;
    m_low = 1'b1;
    wait_us(500);
    t_rel = cyc;
    m_low = 1'b0;
    wait_us(200);
    chk(n_br - br0 == 1, "R2 bus_reset count", n_br - br0, 1);
    chk(n_rx == rx0, "R2 no rx strobe", n_rx - rx0, 0);
    chk(iabs(pr_cyc - t_rel - 30 * US) <= US, "R3 R10 presence delay", pr_cyc - t_rel, 30 * US);
    chk(iabs(pf_cyc - pr_cyc - 120 * US) <= US, "R3 R10 presence width", pf_cyc - pr_cyc, 120 * US);
    chk(n_pr - pr0 == 1 && n_rx == rx0, "R9 presence no slot", n_rx - rx0, 0);
  endtask

  task automatic t_write1();
    int rx0 = n_rx, pr0 = n_pr, t0;
    t0 = cyc;
    m_low = 1'b1;
    wait_us(6);
    m_low = 1'b0;
    wait_us(80);
    chk(n_rx - rx0 == 1, "R4 one strobe", n_rx - rx0, 1);
    chk(last_rx_bit == 1'b1, "R4 bit one", last_rx_bit, 1);
    chk(iabs(last_rx_cyc - t0 - 30 * US) <= US, "R6 R10 sample time", last_rx_cyc - t0, 30 * US);
    chk(n_pr == pr0, "R8 no pull", n_pr - pr0, 0);
  endtask

  task automatic t_write0(input int low_us);
    int rx0 = n_rx, br0 = n_br, t0;
    t0 = cyc;
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    wait_us(40);
    chk(n_rx - rx0 == 1, "R5 one strobe", n_rx - rx0, 1);
    chk(last_rx_bit == 1'b0, "R5 bit zero", last_rx_bit, 0);
    chk(n_br == br0, "R5 no reset", n_br - br0, 0);
    chk(last_rx_cyc - t0 >= low_us * US, "R6 after release", last_rx_cyc - t0, low_us * US);
  endtask

  task automatic t_read(input logic b);
    int rx0 = n_rx, tk0 = n_tk, pr0 = n_pr, t0;
    logic lvl;
    tx_en = 1'b1;
    tx_bit = b;
    t0 = cyc;
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    wait_us(13);
    lvl = line_in;
    wait_us(70);
    tx_en = 1'b0;
    tx_bit = 1'b1;
    chk(n_tk - tk0 == 1, "R7 R8 tx_taken", n_tk - tk0, 1);
    chk(n_rx - rx0 == 1, "R9 single strobe", n_rx - rx0, 1);
    chk(last_rx_bit == b, "R7 R8 read bit", last_rx_bit, b);
    if (!b) begin
      chk(n_pr - pr0 == 1 && pr_cyc - t0 <= US, "R7 pull start", pr_cyc - t0, US);
      chk(iabs(pf_cyc - t0 - 35 * US) <= US, "R7 R10 pull release", pf_cyc - t0, 35 * US);
      chk(lvl == 1'b0, "R7 low at 15us", lvl, 0);
    end else begin
      chk(n_pr == pr0, "R8 no pull for one", n_pr - pr0, 0);
    end
  endtask

  task automatic t_not_armed();
    int tk0 = n_tk, pr0 = n_pr;
    tx_en = 1'b0;
    tx_bit = 1'b0;
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    wait_us(80);
    tx_bit = 1'b1;
    chk(n_tk == tk0, "R8 no tx_taken", n_tk - tk0, 0);
    chk(n_pr == pr0, "R8 no pull unarmed", n_pr - pr0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_bus_reset();
    t_write1();
    t_write0(70);
    t_write0(400);
    t_read(1'b0);
    t_read(1'b1);
    t_not_armed();
    t_bus_reset();
    t_write1();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule